// File: doc/BRIEF.md
# Multi-channel DMA register bank

This block holds the configuration registers of a thirteen-channel DMA engine and decodes them from a 32-bit, word-access memory bus. Two 128-byte windows map onto the bank. Both windows use the same layout, and address bit 8 tells them apart. Reads are combinational. Writes take effect on the clock edge. An address outside both windows reads zero and writes nothing.

Each channel has four words: a base address, a block control word, a channel control word and a tag address. A channel field value of 7 selects the global words instead. These global words sit in pairs, one word of each pair in each window. When a write to a channel's control word sets both its enable and trigger bits, the bank sends a start pulse and the channel number to the transfer logic. When the low interrupt-control word is written, a separate strobe tells the interrupt block to recompute its master flag.

Top module: `dma_regbank`

## Requirements
- R1: After reset every register reads zero, and neither the start pulse nor the interrupt-control strobe is asserted.
- R2: A word whose byte address lies in 0x1F801080–0x1F8010FF (group 0) or 0x1F801500–0x1F80157F (group 1) belongs to the bank. Any other address reads zero and a write to it changes no register.
- R3: Byte address bits 6:4 form a field F. When F is 0 to 6, the channel is F + 7×group. Field 6 in group 1 names no channel: it reads zero and ignores writes.
- R4: Byte address bits 3:2 select the channel word: 0 is the base address, 1 is block control, 2 is channel control and 3 is the tag address.
- R5: The base address keeps only bits 23:0 of the written data. Its bits 31:24 read zero.
- R6: When F is 7, the global slot is 2×(bits 3:2) + group. Slots 0 and 1 are priority control low and high, slots 2 and 3 are interrupt control low and high, slot 5 is the channel-enable word and slot 7 is the interrupt-enable word. All of these keep a full 32-bit value.
- R7: Global slots 4 and 6 read zero and ignore writes.
- R8: A write to channel control whose data has both bit 24 (enable) and bit 28 (trigger) set raises start_pulse for one cycle, in the cycle after the write, with start_chan equal to the channel number. A write with only one of those bits set, or a write to any other word, raises no pulse.
- R9: A write to global slot 2 raises irq_ctl_wr for one cycle after the write. A write to any other slot, slot 3 included, does not.
- R10: Block control (size in bits 15:0, count in bits 31:16), channel control and the tag address store and return all 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 30 | Word address (byte address bits 31:2) |
| wr_en | input | 1 | Write strobe for the addressed word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| start_pulse | output | 1 | One-cycle pulse: a channel was armed |
| start_chan | output | 4 | Index of the armed channel |
| irq_ctl_wr | output | 1 | One-cycle pulse: interrupt control low was written |

## Verification
The bench writes to an address one step outside each window. It also writes to 0x1F801100, which a decoder that looked only at the low bits would send to channel 7's base. A bank that got the window compare wrong would corrupt that register. Group 1 field 6 is written and read back to catch a bank that creates a phantom fourteenth channel or folds that access onto channel 6. The global slots are checked one by one: a bank that swapped the pair interleave would return a high-group value at a low-group address, and slots 4 and 6 must stay zero. Start pulses are matched against a queue of expected channel numbers, so a pulse on a single control bit, on a block-control write, or with the wrong group offset either appears where none is expected or carries the wrong index.

// File: rtl/dma_regbank.sv
module dma_regbank #(
  parameter logic [31:0] BASE_LO = 32'h1F80_1080,
  parameter logic [31:0] BASE_HI = 32'h1F80_1500,
  parameter int          NCH     = 13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:2] addr,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        start_pulse,
  output logic [3:0]  start_chan,
  output logic        irq_ctl_wr
);
  localparam int PER_GRP = 7;
  localparam int NSLOT   = 8;
  localparam logic [31:0] BASE_MASK = 32'h00FF_FFFF;

  logic        in_lo, in_hi, hit, grp, is_glob, ch_ok, slot_ok;
  logic [2:0]  field, slot;
  logic [1:0]  off;
  logic [3:0]  ch;

  assign in_lo   = addr[31:7] == BASE_LO[31:7];
  assign in_hi   = addr[31:7] == BASE_HI[31:7];
  assign hit     = in_lo | in_hi;
  assign grp     = addr[8];
  assign field   = addr[6:4];
  assign off     = addr[3:2];
  assign ch      = {1'b0, field} + (grp ? 4'(PER_GRP) : 4'd0);
  assign is_glob = field == 3'd7;
  assign ch_ok   = hit && !is_glob && (int'(ch) < NCH);
  assign slot    = {off, grp};
  assign slot_ok = hit && is_glob && slot != 3'd4 && slot != 3'd6;

  logic [31:0] chregs [NCH][4];
  logic [31:0] glob   [NSLOT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++)
        for (int j = 0; j < 4; j++) chregs[i][j] <= '0;
      for (int k = 0; k < NSLOT; k++) glob[k] <= '0;
      start_pulse <= 1'b0;
      start_chan  <= '0;
      irq_ctl_wr  <= 1'b0;
    end else begin
      if (wr_en && ch_ok)
        chregs[ch][off] <= (off == 2'd0) ? (wdata & BASE_MASK) : wdata;
      if (wr_en && slot_ok)
        glob[slot] <= wdata;
      start_pulse <= wr_en && ch_ok && off == 2'd2 && wdata[24] && wdata[28];
      if (wr_en && ch_ok && off == 2'd2) start_chan <= ch;
      irq_ctl_wr  <= wr_en && slot_ok && slot == 3'd2;
    end
  end

  always_comb begin
    rdata = '0;
    if (ch_ok)        rdata = chregs[ch][off];
    else if (slot_ok) rdata = glob[slot];
  end

  AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> rdata == 32'd0); // R2
  AST_START_VALID_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> int'(start_chan) < NCH); // R3
  AST_BASE_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !is_glob && off == 2'd0) |-> rdata[31:24] == 8'd0); // R5
  AST_HOLE_SLOTS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && is_glob && (slot == 3'd4 || slot == 3'd6)) |-> rdata == 32'd0); // R7
  AST_START_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> $past(wr_en)); // R8
  AST_IRQ_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ctl_wr |-> $past(wr_en)); // R9
endmodule

// File: tb/dma_regbank_tb_top.sv
`timescale 1ns/1ps
module dma_regbank_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:2] addr = '0;
  logic        wr_en = 0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        start_pulse;
  logic [3:0]  start_chan;
  logic        irq_ctl_wr;

  always #2 clk = ~clk;

  dma_regbank dut_i (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .start_pulse(start_pulse),
    .start_chan(start_chan), .irq_ctl_wr(irq_ctl_wr));

  int compared = 0, mismatched = 0;
  int irq_exp = 0, irq_obs = 0;
  logic chk = 0, done = 0;
  logic [31:0] exp_q [$];
  string       tag_q [$];
  int          st_q  [$];

  function automatic logic [31:0] adr(input bit g, input int f, input int o);
    return (g ? 32'h1F80_1500 : 32'h1F80_1080) | 32'(f << 4) | 32'(o << 2);
  endfunction

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(posedge clk); #1; addr = a[31:2]; wdata = d; wr_en = 1;
    @(posedge clk); #1; wr_en = 0;
  endtask

  task automatic rd(input logic [31:0] a, input logic [31:0] e, input string t);
    @(posedge clk); #1; addr = a[31:2];
    exp_q.push_back(e); tag_q.push_back(t); chk = 1;
    @(posedge clk); #1; chk = 0;
  endtask

  always @(negedge clk) begin
    if (chk) begin
      logic [31:0] e; string t;
      e = exp_q.pop_front(); t = tag_q.pop_front();
      compared++;
      if (rdata !== e) begin
        mismatched++;
        $display("FAIL %s: rdata=%h expected=%h", t, rdata, e);
      end
    end
    if (rst_n && irq_ctl_wr) irq_obs++;
    if (rst_n && start_pulse) begin
      compared++;
      if (st_q.size() == 0) begin
        mismatched++;
        $display("FAIL R8: start_pulse chan=%0d expected=none", start_chan);
      end else begin
        int e; e = st_q.pop_front();
        if (int'(start_chan) != e) begin
          mismatched++;
          $display("FAIL R8: start_chan=%0d expected=%0d", start_chan, e);
        end
      end
    end
  end

  task automatic finish_run();
    compared++;
    if (st_q.size() != 0) begin
      mismatched++;
      $display("FAIL R8: missing start pulses actual=0 expected=%0d", st_q.size());
    end
    compared++;
    if (irq_obs != irq_exp) begin
      mismatched++;
      $display("FAIL R9: irq strobes actual=%0d expected=%0d", irq_obs, irq_exp);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    compared++;
    if (start_pulse !== 1'b0 || irq_ctl_wr !== 1'b0) begin
      mismatched++;
      $display("FAIL R1: pulses=%b%b expected=00", start_pulse, irq_ctl_wr);
    end
    rst_n = 1;
    // R1 reset state
    rd(adr(0,3,1), 32'h0, "R1 ch3 block");
    rd(adr(1,7,1), 32'h0, "R1 slot3");
    // R5 base masking
    wr(adr(0,0,0), 32'hFFFF_FFFF);
    rd(adr(0,0,0), 32'h00FF_FFFF, "R5 ch0 base");
    // R4 word order, R10 full width
    wr(adr(0,3,0), 32'h0012_3456);
    wr(adr(0,3,1), 32'hABCD_0010);
    wr(adr(0,3,2), 32'h0007_0603);
    wr(adr(0,3,3), 32'hDEAD_BEEF);
    rd(adr(0,3,0), 32'h0012_3456, "R4 base");
    rd(adr(0,3,1), 32'hABCD_0010, "R10 block");
    rd(adr(0,3,2), 32'h0007_0603, "R10 ctrl");
    rd(adr(0,3,3), 32'hDEAD_BEEF, "R4 tag");
    // R3 group offset
    wr(adr(1,2,1), 32'h1111_2222);
    rd(adr(1,2,1), 32'h1111_2222, "R3 ch9 block");
    rd(adr(0,2,1), 32'h0, "R3 ch2 untouched");
    wr(adr(1,5,3), 32'hCAFE_F00D);
    rd(adr(1,5,3), 32'hCAFE_F00D, "R3 ch12 tag");
    wr(adr(1,6,1), 32'h5555_AAAA);
    rd(adr(1,6,1), 32'h0, "R3 phantom ch13");
    rd(adr(0,6,1), 32'h0, "R3 ch6 untouched");
    // R6 global interleave
    wr(adr(0,7,0), 32'h0765_4321);
    wr(adr(1,7,0), 32'h0000_0ABC);
    irq_exp++; wr(adr(0,7,1), 32'h00FF_0000);
    wr(adr(1,7,1), 32'h3F3F_3F3F);
    wr(adr(1,7,2), 32'h0000_1FFF);
    wr(adr(1,7,3), 32'h0000_0042);
    rd(adr(0,7,0), 32'h0765_4321, "R6 slot0");
    rd(adr(1,7,0), 32'h0000_0ABC, "R6 slot1");
    rd(adr(0,7,1), 32'h00FF_0000, "R6 slot2");
    rd(adr(1,7,1), 32'h3F3F_3F3F, "R6 slot3");
    rd(adr(1,7,2), 32'h0000_1FFF, "R6 slot5");
    rd(adr(1,7,3), 32'h0000_0042, "R6 slot7");
    // R7 holes
    wr(adr(0,7,2), 32'hFFFF_FFFF);
    wr(adr(0,7,3), 32'hFFFF_FFFF);
    rd(adr(0,7,2), 32'h0, "R7 slot4");
    rd(adr(0,7,3), 32'h0, "R7 slot6");
    // R2 windows
    wr(32'h1F80_1100, 32'h0012_0000);
    wr(32'h1F80_1000, 32'h0034_0000);
    wr(32'h1F80_1580, 32'h0056_0000);
    rd(adr(1,0,0), 32'h0, "R2 ch7 base untouched");
    rd(32'h1F80_1100, 32'h0, "R2 outside read");
    rd(32'h1F80_1580, 32'h0, "R2 above hi window");
    rd(adr(0,0,0), 32'h00FF_FFFF, "R2 ch0 base untouched");
    // R8 start detection
    st_q.push_back(4);  wr(adr(0,4,2), 32'h1100_0000);
    st_q.push_back(11); wr(adr(1,4,2), 32'h1100_0200);
    wr(adr(0,5,2), 32'h0100_0000);
    wr(adr(0,5,2), 32'h1000_0000);
    wr(adr(0,5,1), 32'h1100_0000);
    rd(adr(0,4,2), 32'h1100_0000, "R10 ctrl ch4");
    rd(adr(0,5,1), 32'h1100_0000, "R10 block ch5");
    // R9 no strobe for slot 3
    wr(adr(1,7,1), 32'h1);
    repeat (3) @(posedge clk);
    done = 1;
    finish_run();
  end
endmodule